// File: doc/BRIEF.md
# Supply Monitor Mode Decode and Fault Gating

This block sits behind the voltage comparators of a multichannel supply monitor. Two mode pins and a power-mode configuration bit are decoded into one of four operating modes: idle, active, sleep and deep sleep. The decoded mode is registered, and it decides for each channel which comparator flags count as faults. Over-voltage is watched in every mode. Under-voltage is dropped in idle. Channels flagged for automatic masking are fully silenced while the monitor sleeps.

Qualified violations set sticky per-channel fault bits. A single active-low interrupt stays asserted while any fault bit is set. The host clears faults through a write-one-to-clear port. Rails below their OFF threshold are reported on a separate status vector that never reaches the interrupt. Each channel also has a host-owned under-voltage interrupt enable for rails that software switches on and off. Auto-masking never changes that enable.

Top module: `rail_mon_gate`

## Requirements
- R1: The registered mode code takes, one clock edge after the pins, the value 0 (idle) when the activity pin is low whatever the sleep pin; 1 (active) when both pins are high; 2 (sleep) when activity is high, sleep is low and the power-mode bit is 1; 3 (deep sleep) when activity is high, sleep is low and the power-mode bit is 0.
- R2: A channel whose enable input is low never sets its OV or UV fault bit and never sets its OFF status bit.
- R3: An enabled channel that is not auto-masked sets its OV fault bit at the clock edge where its raw OV flag is high, in every mode.
- R4: While the registered mode is idle, no UV fault bit is set, whatever the raw UV flags and enables.
- R5: In active, sleep and deep sleep modes, an enabled, unmasked channel sets its UV fault bit only when both its raw UV flag and its host UV interrupt enable are high.
- R6: In sleep and deep sleep, a channel whose auto-mask bit is high sets neither fault bit. In idle and active modes the auto-mask bit has no effect.
- R7: The OFF status bit of an enabled channel follows its raw OFF flag one clock edge later. OFF flags never set a fault and never assert the interrupt.
- R8: Fault bits are sticky. Clear-port bits [N-1:0] clear the OV faults and bits [2N-1:N] clear the UV faults, where 1 clears and 0 keeps. A violation in the same cycle as a clear of that bit leaves the bit set.
- R9: The interrupt output is low exactly when at least one OV or UV fault bit is set.
- R10: Gating uses the mode registered at the previous edge, so a pin change takes effect one edge later. Fault bits that are already set survive mode changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_i | input | 1 | Activity pin |
| slp_i | input | 1 | Sleep pin, active low |
| pwr_sel_i | input | 1 | Power-mode bit, 1 = sleep, 0 = deep sleep |
| ch_en_i | input | NUM_CH | Per-channel monitoring enable |
| uv_ie_i | input | NUM_CH | Per-channel host UV interrupt enable |
| amsk_i | input | NUM_CH | Per-channel auto-mask bit for sleep modes |
| ov_raw_i | input | NUM_CH | Raw over-voltage comparator flags |
| uv_raw_i | input | NUM_CH | Raw under-voltage comparator flags |
| off_raw_i | input | NUM_CH | Raw below-OFF-threshold flags |
| clr_we_i | input | 1 | Clear-port write strobe |
| clr_data_i | input | 2*NUM_CH | Clear mask, UV half above OV half |
| mode_o | output | 2 | Registered mode code |
| fault_ov_o | output | NUM_CH | Sticky OV fault bits |
| fault_uv_o | output | NUM_CH | Sticky UV fault bits |
| off_sts_o | output | NUM_CH | OFF status bits |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with NUM_CH set to 4. At that size all eight pin and power-bit combinations can be swept against 64 per-channel patterns. Each pattern covers enable, UV interrupt enable, auto-mask and the three raw flags, rotated so that the four channels see different combinations in the same trial. Every mode then meets every gating combination on every channel position, and the expected fault vectors are computed from the mode rules. Directed sequences cover the corner cases: the clear-versus-violation race, the one-edge lag on a mode change, and faults held across a mode change.

// File: rtl/rmg_pkg.sv
package rmg_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_ACTIVE = 2'd1,
    MODE_SLEEP  = 2'd2,
    MODE_DEEP   = 2'd3
  } mon_mode_e;

  function automatic logic mode_is_sleepy(input mon_mode_e m);
    return (m == MODE_SLEEP) || (m == MODE_DEEP);
  endfunction
endpackage

// File: rtl/rmg_mode_dec.sv
module rmg_mode_dec
  import rmg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      act_i,
  input  logic      slp_i,
  input  logic      pwr_sel_i,
  output mon_mode_e mode_o
);
  mon_mode_e mode_d, mode_q;

  always_comb begin
    mode_d = MODE_IDLE;
    if (act_i) begin
      if (slp_i)          mode_d = MODE_ACTIVE;
      else if (pwr_sel_i) mode_d = MODE_SLEEP;
      else                mode_d = MODE_DEEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_IDLE;
    else        mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  // R1: a low activity pin always lands in idle
  p_idle_on_low_act_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !act_i |=> (mode_q == MODE_IDLE));
  // R1: sleep pin low with activity high never gives active or idle
  p_sleep_family_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i && !slp_i) |=> mode_is_sleepy(mode_q));
endmodule

// File: rtl/rmg_chan_gate.sv
module rmg_chan_gate
  import rmg_pkg::*;
(
  input  mon_mode_e mode_i,
  input  logic      en_i,
  input  logic      uv_ie_i,
  input  logic      amsk_i,
  input  logic      ov_i,
  input  logic      uv_i,
  input  logic      off_i,
  output logic      ov_hit_o,
  output logic      uv_hit_o,
  output logic      off_o
);
  logic silenced;
  logic uv_allowed;

  always_comb begin
    silenced   = amsk_i && mode_is_sleepy(mode_i);
    uv_allowed = (mode_i != MODE_IDLE) && uv_ie_i;
    ov_hit_o   = en_i && !silenced && ov_i;
    uv_hit_o   = en_i && !silenced && uv_allowed && uv_i;
    off_o      = en_i && off_i;
  end
endmodule

// File: rtl/rmg_fault_bank.sv
module rmg_fault_bank #(
  parameter int NUM_CH = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CH-1:0]   ov_hit_i,
  input  logic [NUM_CH-1:0]   uv_hit_i,
  input  logic [NUM_CH-1:0]   off_i,
  input  logic                clr_we_i,
  input  logic [2*NUM_CH-1:0] clr_data_i,
  output logic [NUM_CH-1:0]   fault_ov_o,
  output logic [NUM_CH-1:0]   fault_uv_o,
  output logic [NUM_CH-1:0]   off_sts_o,
  output logic                irq_n_o
);
  localparam int CW = 2 * NUM_CH;

  logic [NUM_CH-1:0] ov_q, ov_d, uv_q, uv_d, off_q;
  logic [NUM_CH-1:0] clr_ov, clr_uv;

  always_comb begin
    clr_ov = clr_we_i ? clr_data_i[NUM_CH-1:0]  : '0;
    clr_uv = clr_we_i ? clr_data_i[CW-1:NUM_CH] : '0;
    ov_d   = (ov_q & ~clr_ov) | ov_hit_i;
    uv_d   = (uv_q & ~clr_uv) | uv_hit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q  <= '0;
      uv_q  <= '0;
      off_q <= '0;
    end else begin
      ov_q  <= ov_d;
      uv_q  <= uv_d;
      off_q <= off_i;
    end
  end

  assign fault_ov_o = ov_q;
  assign fault_uv_o = uv_q;
  assign off_sts_o  = off_q;
  assign irq_n_o    = ~(|ov_q | |uv_q);

  // R8: an uncleared fault bit stays set
  p_sticky_ov_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(ov_q) & ~$past(clr_ov)) & ~ov_q) == '0));
  p_sticky_uv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(uv_q) & ~$past(clr_uv)) & ~uv_q) == '0));
  // R8: a violation wins over a same-cycle clear
  p_hit_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|ov_hit_i) |=> ((ov_q & $past(ov_hit_i)) == $past(ov_hit_i)));
endmodule

// File: rtl/rail_mon_gate.sv
module rail_mon_gate
  import rmg_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                act_i,
  input  logic                slp_i,
  input  logic                pwr_sel_i,
  input  logic [NUM_CH-1:0]   ch_en_i,
  input  logic [NUM_CH-1:0]   uv_ie_i,
  input  logic [NUM_CH-1:0]   amsk_i,
  input  logic [NUM_CH-1:0]   ov_raw_i,
  input  logic [NUM_CH-1:0]   uv_raw_i,
  input  logic [NUM_CH-1:0]   off_raw_i,
  input  logic                clr_we_i,
  input  logic [2*NUM_CH-1:0] clr_data_i,
  output logic [1:0]          mode_o,
  output logic [NUM_CH-1:0]   fault_ov_o,
  output logic [NUM_CH-1:0]   fault_uv_o,
  output logic [NUM_CH-1:0]   off_sts_o,
  output logic                irq_n_o
);
  mon_mode_e         mode_q;
  logic [NUM_CH-1:0] ov_hit, uv_hit, off_hit;

  rmg_mode_dec u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .act_i     (act_i),
    .slp_i     (slp_i),
    .pwr_sel_i (pwr_sel_i),
    .mode_o    (mode_q)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    rmg_chan_gate u_gate (
      .mode_i   (mode_q),
      .en_i     (ch_en_i[g]),
      .uv_ie_i  (uv_ie_i[g]),
      .amsk_i   (amsk_i[g]),
      .ov_i     (ov_raw_i[g]),
      .uv_i     (uv_raw_i[g]),
      .off_i    (off_raw_i[g]),
      .ov_hit_o (ov_hit[g]),
      .uv_hit_o (uv_hit[g]),
      .off_o    (off_hit[g])
    );
  end

  rmg_fault_bank #(.NUM_CH(NUM_CH)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .ov_hit_i   (ov_hit),
    .uv_hit_i   (uv_hit),
    .off_i      (off_hit),
    .clr_we_i   (clr_we_i),
    .clr_data_i (clr_data_i),
    .fault_ov_o (fault_ov_o),
    .fault_uv_o (fault_uv_o),
    .off_sts_o  (off_sts_o),
    .irq_n_o    (irq_n_o)
  );

  assign mode_o = mode_q;

  // R4: idle never produces a new UV fault
  p_idle_no_uv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_IDLE) |=> ((fault_uv_o & ~$past(fault_uv_o)) == '0));
  // R2: disabled channels never gain a fault
  p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((((fault_ov_o & ~$past(fault_ov_o)) |
               (fault_uv_o & ~$past(fault_uv_o))) & ~$past(ch_en_i)) == '0));
  // R6: masked channels stay silent while sleeping
  p_masked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_is_sleepy(mode_q) |=> ((((fault_ov_o & ~$past(fault_ov_o)) |
               (fault_uv_o & ~$past(fault_uv_o))) & $past(amsk_i)) == '0));
  // R7: OFF flags alone never pull the interrupt low
  p_off_no_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_n_o && ov_hit == '0 && uv_hit == '0) |=> irq_n_o);
endmodule

// File: tb/rail_mon_gate_bench.sv
module rail_mon_gate_bench;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         act, slp, pwr;
  logic [N-1:0] en, uvie, amsk, ovr, uvr, offr;
  logic         clr_we;
  logic [2*N-1:0] clr_data;
  logic [1:0]   mode;
  logic [N-1:0] f_ov, f_uv, off_sts;
  logic         irq_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  rail_mon_gate #(.NUM_CH(N)) u_rail_mon_gate (
    .clk(clk), .rst_n(rst_n), .act_i(act), .slp_i(slp), .pwr_sel_i(pwr),
    .ch_en_i(en), .uv_ie_i(uvie), .amsk_i(amsk), .ov_raw_i(ovr),
    .uv_raw_i(uvr), .off_raw_i(offr), .clr_we_i(clr_we), .clr_data_i(clr_data),
    .mode_o(mode), .fault_ov_o(f_ov), .fault_uv_o(f_uv),
    .off_sts_o(off_sts), .irq_n_o(irq_n)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [1:0] exp_mode(input logic a, input logic s, input logic p);
    if (!a) return 2'd0;
    if (s)  return 2'd1;
    return p ? 2'd2 : 2'd3;
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [1:0]   m;
    logic [N-1:0] e_ov, e_uv, e_off;
    rst_n = 1'b0; act = 0; slp = 0; pwr = 0;
    en = '0; uvie = '0; amsk = '0; ovr = '0; uvr = '0; offr = '0;
    clr_we = 0; clr_data = '0;
    repeat (3) @(negedge clk);
    check("R1 reset mode", 32'(mode), 32'd0);
    check("R9 reset irq", 32'(irq_n), 32'd1);
    check("R8 reset faults", 32'({f_ov, f_uv, off_sts}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep: every pin combination against rotated per-channel patterns
    for (int pins = 0; pins < 8; pins++) begin
      for (int c = 0; c < 64; c++) begin
        act = pins[2]; slp = pins[1]; pwr = pins[0];
        ovr = '0; uvr = '0; offr = '0;
        clr_we = 1; clr_data = '1;
        @(negedge clk);
        clr_we = 0; clr_data = '0;
        m = exp_mode(act, slp, pwr);
        check("R1 mode decode", 32'(mode), 32'(m));
        for (int i = 0; i < N; i++) begin
          logic [5:0] code;
          logic masked;
          code = 6'((c + i * 11) & 63);
          en[i] = code[0]; uvie[i] = code[1]; amsk[i] = code[2];
          ovr[i] = code[3]; uvr[i] = code[4]; offr[i] = code[5];
          masked = amsk[i] && (m >= 2);
          e_ov[i]  = en[i] && !masked && ovr[i];
          e_uv[i]  = en[i] && !masked && uvie[i] && uvr[i] && (m != 0);
          e_off[i] = en[i] && offr[i];
        end
        @(negedge clk);
        ovr = '0; uvr = '0; offr = '0;
        check("R3 R6 R2 OV faults", 32'(f_ov), 32'(e_ov));
        check("R4 R5 R6 UV faults", 32'(f_uv), 32'(e_uv));
        check("R7 OFF status", 32'(off_sts), 32'(e_off));
        check("R9 irq level", 32'(irq_n), 32'(!(|{e_ov, e_uv})));
      end
    end

    // Directed: sticky, clear, race
    act = 1; slp = 1; pwr = 0; en = '1; uvie = '1; amsk = '0;
    clr_we = 1; clr_data = '1; @(negedge clk);
    clr_we = 0; clr_data = '0;
    ovr = 4'b0101; uvr = 4'b0010; @(negedge clk);
    ovr = '0; uvr = '0; repeat (3) @(negedge clk);
    check("R8 sticky OV", 32'(f_ov), 32'h5);
    check("R8 sticky UV", 32'(f_uv), 32'h2);
    clr_we = 1; clr_data = 8'b0000_0001; @(negedge clk);
    clr_we = 0;
    check("R8 partial clear OV", 32'(f_ov), 32'h4);
    check("R8 zero bits keep UV", 32'(f_uv), 32'h2);
    clr_we = 1; clr_data = 8'b0010_0100; ovr = 4'b0100; @(negedge clk);
    clr_we = 0; ovr = '0;
    check("R8 violation beats clear", 32'(f_ov), 32'h4);
    check("R8 UV clear", 32'(f_uv), 32'h0);
    check("R9 irq with OV only", 32'(irq_n), 32'd0);
    clr_we = 1; clr_data = '1; @(negedge clk);
    clr_we = 0;
    check("R9 irq released", 32'(irq_n), 32'd1);

    // R7: OFF never interrupts
    offr = 4'b1111; repeat (2) @(negedge clk);
    check("R7 off status", 32'(off_sts), 32'hF);
    check("R7 off no irq", 32'(irq_n), 32'd1);
    offr = '0;

    // R10: pin change to idle takes effect one edge later
    act = 0; uvr = 4'b1000; @(negedge clk);
    check("R10 old mode still gates", 32'(f_uv), 32'h8);
    check("R10 mode now idle", 32'(mode), 32'd0);
    uvr = 4'b0001; @(negedge clk);
    uvr = '0;
    check("R10 R4 idle drops UV", 32'(f_uv), 32'h8);
    act = 1; slp = 0; pwr = 1; repeat (2) @(negedge clk);
    check("R10 fault kept across mode change", 32'(f_uv), 32'h8);
    check("R10 sleep mode", 32'(mode), 32'd2);

    done = 1;
    summary();
    $finish;
  end
endmodule